// File: doc/BRIEF.md
# Successive-Approximation Serial Conversion Sequencer

This block is the digital sequencer of a successive-approximation converter with a three-wire serial output. The analog parts stay outside the block. It drives a trial code to an external DAC and reads back a single comparator decision. It also controls the sample/hold switch, raises a busy flag while a frame runs, and shifts the finished code out on a serial line with an output enable. Everything is timed by the serial clock of the host.

A frame starts when the active-low select goes low. Each frame is sixteen serial clocks long. Four zero bits come first, then the twelve result bits, most significant first. While select stays low, frames repeat back to back with one idle clock between them. When select is raised between frames, each frame is started by the host. Raising select, or raising the shutdown input, clears the sequencer at once without waiting for a clock edge. A conversion cut short in this way gives no valid result. A one-clock valid pulse and a parallel copy of the code are provided for checking.

Top module: `sar_seq_top`

## Requirements
- R1: While `cs_n_i` is high, `status_o`, `hold_o`, `sdo_oe_o`, `sdo_o`, `valid_o` and `code_o` are all zero, with no clock needed. Raising `cs_n_i` mid-frame clears them at once.
- R2: As soon as `cs_n_i` goes low (with `shdn_i` low), `hold_o`, `status_o` and `sdo_oe_o` go to 1 and `sdo_o` is 0, before any clock.
- R3: Rising edges 1 to 4 of a frame sample `sdo_o` as 0.
- R4: Rising edges 5 to 16 of a frame sample the result bits in order from bit 11 down to bit 0. `sdo_o` only changes after a falling edge of `sclk_i`.
- R5: The code is straight binary. With a comparator that returns 1 when the input is at or above the trial code, the twelve serial bits equal the input code.
- R6: Before rising edge 4, `trial_o` holds only bit 11 set. At rising edges 4 to 15, the bit under trial is kept if `cmp_i` is 1 and cleared if it is 0, and the next lower bit is set.
- R7: `status_o` and `hold_o` stay high from the start of a frame through rising edge 16. They are low for exactly one clock, up to rising edge 17. If `cs_n_i` stays low, rising edge 18 is edge 1 of the next frame.
- R8: `valid_o` goes high on rising edge 16 and low on rising edge 17. At that point `code_o` shows the twelve-bit result, and it holds that value until the next valid pulse or until a clear.
- R9: A high `shdn_i` clears the block in the same way as R1, with no clock needed. When `shdn_i` falls while `cs_n_i` is low, a new frame starts from edge 1.
- R10: After a frame is aborted by `cs_n_i`, the next falling edge of `cs_n_i` starts a complete, correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock from the host; all sequencing runs on it |
| cs_n_i | input | 1 | Active-low select; high clears the block asynchronously |
| shdn_i | input | 1 | Shutdown; high clears and aborts asynchronously |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above `trial_o` |
| trial_o | output | RES | Trial code for the external DAC |
| hold_o | output | 1 | 1 = hold the sampled input, 0 = track |
| status_o | output | 1 | High while a conversion frame is running |
| sdo_o | output | 1 | Serial data, zeros then result MSB first |
| sdo_oe_o | output | 1 | Output enable for the serial data driver |
| valid_o | output | 1 | One-clock pulse after the last result bit |
| code_o | output | RES | Parallel copy of the last finished result |

## Verification
The assertions assume that `sclk_i` toggles only while the clear is low, or is otherwise kept away from the moments when `cs_n_i` or `shdn_i` change. They also assume that `cmp_i` settles within the low half of the clock that follows a trial update. The bench meets both assumptions. It moves select and shutdown only inside the low phase of the clock, and it models the comparator as a plain magnitude compare between a held input code and `trial_o`. Input codes come from a seeded random source, mixed with all-zero, all-one, midscale and alternating patterns. Frames run back to back, one at a time under host control, and cut short by select or by shutdown.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Position of the sequencer inside one frame, derived from the edge count
    typedef enum logic [2:0] {
        PH_LEAD,     // leading zero clocks before the first trial
        PH_ARM,      // load the MSB-only trial code
        PH_RESOLVE,  // decide one bit and arm the next lower one
        PH_LAST,     // final output clock: publish the result
        PH_DEAD      // idle clock between frames
    } sar_phase_e;

    // cnt = rising edges already seen in the current frame
    function automatic sar_phase_e phase_of(input int cnt, input int lead, input int res);
        if (cnt == lead - 2)                         return PH_ARM;
        if (cnt >= lead - 1 && cnt <= lead + res - 2) return PH_RESOLVE;
        if (cnt == lead + res - 1)                   return PH_LAST;
        if (cnt == lead + res)                       return PH_DEAD;
        return PH_LEAD;
    endfunction

    // Bit index decided at the coming rising edge
    function automatic int step_bit(input int cnt, input int lead, input int res);
        return res - 1 - (cnt - (lead - 1));
    endfunction

    // Bit index driven at the coming falling edge
    function automatic int out_bit(input int cnt, input int lead, input int res);
        return res - 1 - (cnt - lead);
    endfunction

    function automatic logic in_data_window(input int cnt, input int lead, input int res);
        return (cnt >= lead) && (cnt < lead + res);
    endfunction

endpackage

// File: rtl/sar_frame_ctr.sv
module sar_frame_ctr #(
    parameter int FRAME = 16,
    parameter int CW    = 5
) (
    input  logic          sclk_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;

    // Counts rising edges 0..FRAME; the FRAME value marks the idle clock
    always_ff @(posedge sclk_i or posedge clr_i) begin
        if (clr_i)
            cnt_q <= '0;
        else if (int'(cnt_q) == FRAME)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int RES  = 12,
    parameter int LEAD = 4,
    parameter int CW   = 5
) (
    input  logic           sclk_i,
    input  logic           clr_i,
    input  logic [CW-1:0]  cnt_i,
    input  logic           cmp_i,
    output logic [RES-1:0] trial_o,
    output logic [RES-1:0] code_o,
    output logic           valid_o
);
    localparam logic [RES-1:0] MSB_ONE = {1'b1, {(RES-1){1'b0}}};

    sar_phase_e     ph;
    int             sb;
    logic [RES-1:0] trial_q, trial_d, code_q;
    logic           valid_q;

    always_comb begin
        ph      = phase_of(int'(cnt_i), LEAD, RES);
        sb      = step_bit(int'(cnt_i), LEAD, RES);
        trial_d = trial_q;
        case (ph)
            PH_ARM: trial_d = MSB_ONE;
            PH_RESOLVE: begin
                for (int b = 0; b < RES; b++) begin
                    if (b == sb)     trial_d[b] = cmp_i;
                    if (b == sb - 1) trial_d[b] = 1'b1;
                end
            end
            default: trial_d = trial_q;
        endcase
    end

    always_ff @(posedge sclk_i or posedge clr_i) begin
        if (clr_i) begin
            trial_q <= '0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            trial_q <= trial_d;
            valid_q <= (ph == PH_LAST);
            if (ph == PH_LAST)
                code_q <= trial_q;
        end
    end

    assign trial_o = trial_q;
    assign code_o  = code_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out
    import sar_seq_pkg::*;
#(
    parameter int RES  = 12,
    parameter int LEAD = 4,
    parameter int CW   = 5
) (
    input  logic           sclk_i,
    input  logic           clr_i,
    input  logic [CW-1:0]  cnt_i,
    input  logic [RES-1:0] word_i,
    output logic           sdo_o
);
    logic sdo_q, sdo_d;
    int   ob;

    always_comb begin
        ob    = out_bit(int'(cnt_i), LEAD, RES);
        sdo_d = 1'b0;
        if (in_data_window(int'(cnt_i), LEAD, RES)) begin
            for (int b = 0; b < RES; b++)
                if (b == ob) sdo_d = word_i[b];
        end
    end

    // Data moves on the falling edge so it is settled at the next rising edge
    always_ff @(negedge sclk_i or posedge clr_i) begin
        if (clr_i) sdo_q <= 1'b0;
        else       sdo_q <= sdo_d;
    end

    assign sdo_o = sdo_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
    parameter int RES  = 12,
    parameter int LEAD = 4
) (
    input  logic           sclk_i,
    input  logic           cs_n_i,
    input  logic           shdn_i,
    input  logic           cmp_i,
    output logic [RES-1:0] trial_o,
    output logic           hold_o,
    output logic           status_o,
    output logic           sdo_o,
    output logic           sdo_oe_o,
    output logic           valid_o,
    output logic [RES-1:0] code_o
);
    localparam int FRAME = LEAD + RES;
    localparam int CW    = $clog2(FRAME + 1);

    logic          clr;
    logic [CW-1:0] cnt;
    logic          busy;

    assign clr  = cs_n_i | shdn_i;
    assign busy = ~clr & (int'(cnt) != FRAME);

    sar_frame_ctr #(.FRAME(FRAME), .CW(CW)) u_ctr (
        .sclk_i (sclk_i),
        .clr_i  (clr),
        .cnt_o  (cnt)
    );

    sar_trial_reg #(.RES(RES), .LEAD(LEAD), .CW(CW)) u_sar (
        .sclk_i  (sclk_i),
        .clr_i   (clr),
        .cnt_i   (cnt),
        .cmp_i   (cmp_i),
        .trial_o (trial_o),
        .code_o  (code_o),
        .valid_o (valid_o)
    );

    sar_shift_out #(.RES(RES), .LEAD(LEAD), .CW(CW)) u_sdo (
        .sclk_i (sclk_i),
        .clr_i  (clr),
        .cnt_i  (cnt),
        .word_i (trial_o),
        .sdo_o  (sdo_o)
    );

    assign hold_o   = busy;
    assign status_o = busy;
    assign sdo_oe_o = ~clr;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES  = 12,
    parameter int LEAD = 4
) (
    input logic           sclk_i,
    input logic           cs_n_i,
    input logic           shdn_i,
    input logic           sdo_o,
    input logic           status_o,
    input logic           valid_o,
    input logic [RES-1:0] trial_o,
    input logic [RES-1:0] code_o
);
    localparam int FRAME = LEAD + RES;
    localparam int CW    = $clog2(FRAME + 1);
    localparam logic [RES-1:0] MSB_ONE = {1'b1, {(RES-1){1'b0}}};

    logic          clr;
    logic [CW-1:0] edges;
    logic          armed;

    assign clr = cs_n_i | shdn_i;

    always_ff @(posedge sclk_i or posedge clr) begin
        if (clr) begin
            edges <= '0;
            armed <= 1'b0;
        end else begin
            edges <= (int'(edges) == FRAME) ? '0 : edges + 1'b1;
            armed <= 1'b1;
        end
    end

    // R3
    lead_zero_chk: assert property (@(posedge sclk_i) disable iff (clr)
        (int'(edges) < LEAD) |-> (sdo_o == 1'b0));

    // R6
    msb_trial_chk: assert property (@(posedge sclk_i) disable iff (clr)
        (int'(edges) == LEAD - 1) |-> (trial_o == MSB_ONE));

    // R7
    one_dead_clk_chk: assert property (@(posedge sclk_i) disable iff (clr)
        !status_o |=> status_o);

    // R8
    valid_pulse_chk: assert property (@(posedge sclk_i) disable iff (clr)
        valid_o |=> !valid_o);

    // R8
    code_hold_chk: assert property (@(posedge sclk_i) disable iff (clr)
        (armed && !$rose(valid_o)) |-> $stable(code_o));
endmodule

bind sar_seq_top sar_seq_chk #(.RES(RES), .LEAD(LEAD)) u_chk (
    .sclk_i   (sclk_i),
    .cs_n_i   (cs_n_i),
    .shdn_i   (shdn_i),
    .sdo_o    (sdo_o),
    .status_o (status_o),
    .valid_o  (valid_o),
    .trial_o  (trial_o),
    .code_o   (code_o)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
    localparam int CLK_PERIOD = 40;
    localparam int RES   = 12;
    localparam int LEAD  = 4;
    localparam int FRAME = LEAD + RES;

    logic           sclk = 1'b0;
    logic           cs_n = 1'b1;
    logic           shdn = 1'b0;
    logic           cmp;
    logic [RES-1:0] vin  = '0;
    logic [RES-1:0] trial, code;
    logic           hold, status, sdo, sdo_oe, valid;

    // Ideal comparator: 1 when the held input is at or above the trial code
    assign cmp = (vin >= trial);

    sar_seq_top #(.RES(RES), .LEAD(LEAD)) dut (
        .sclk_i   (sclk),
        .cs_n_i   (cs_n),
        .shdn_i   (shdn),
        .cmp_i    (cmp),
        .trial_o  (trial),
        .hold_o   (hold),
        .status_o (status),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe),
        .valid_o  (valid),
        .code_o   (code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic           s_sdo, s_stat, s_hold;
    logic [RES-1:0] s_trial;
    logic           h_valid, h_stat;
    logic [RES-1:0] h_code;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: sample before the rising edge, then in the high half
    task automatic cyc();
        #(CLK_PERIOD/4);
        s_sdo = sdo; s_stat = status; s_hold = hold; s_trial = trial;
        #(CLK_PERIOD/4);
        sclk = 1'b1;
        #(CLK_PERIOD/4);
        h_valid = valid; h_stat = status; h_code = code;
        #(CLK_PERIOD/4);
        sclk = 1'b0;
    endtask

    function automatic int exp_trial(input int v, input int j);
        int hi;
        hi = ~((1 << (RES - j)) - 1) & ((1 << RES) - 1);
        return (v & hi) | (1 << (RES - 1 - j));
    endfunction

    task automatic run_frame(input int v);
        int word;
        word = 0;
        vin  = v[RES-1:0];
        for (int k = 1; k <= FRAME; k++) begin
            cyc();
            check("R7 busy inside frame", int'(s_stat), 1);
            if (k <= LEAD)
                check("R3 leading zero bit", int'(s_sdo), 0);
            else begin
                check("R4 serial bit order", int'(s_sdo), (v >> (FRAME - k)) & 1);
                word = (word << 1) | int'(s_sdo);
            end
            if (k >= LEAD && k < FRAME)
                check("R6 trial code", int'(s_trial), exp_trial(v, k - LEAD));
            if (k == FRAME - 1)
                check("R8 valid low before last bit", int'(h_valid), 0);
            if (k == FRAME) begin
                check("R8 valid pulse", int'(h_valid), 1);
                check("R8 parallel code", int'(h_code), v);
                check("R7 status drops after edge 16", int'(h_stat), 0);
            end
        end
        check("R5 straight binary result", word, v);
    endtask

    task automatic dead_clk();
        cyc();
        check("R7 idle clock status", int'(s_stat), 0);
        check("R7 idle clock sample mode", int'(s_hold), 0);
        check("R7 next frame starts", int'(h_stat), 1);
        check("R8 valid pulse ends", int'(h_valid), 0);
    endtask

    task automatic check_cleared(input string req);
        check(req, int'(status), 0);
        check(req, int'(hold), 0);
        check(req, int'(sdo_oe), 0);
        check(req, int'(sdo), 0);
        check(req, int'(valid), 0);
        check(req, int'(code), 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        int v;
        void'($urandom(32'd20240611));
        cyc(); cyc();
        check_cleared("R1 deselected state");

        // Continuous mode with directed corners then random codes
        cs_n = 1'b0;
        #1;
        check("R2 status on select", int'(status), 1);
        check("R2 hold on select", int'(hold), 1);
        check("R2 output enabled", int'(sdo_oe), 1);
        check("R2 first bit zero", int'(sdo), 0);
        run_frame(0);    dead_clk();
        run_frame(4095); dead_clk();
        run_frame(2048); dead_clk();
        run_frame(2047); dead_clk();
        run_frame(1365); dead_clk();
        run_frame(2730); dead_clk();
        for (int i = 0; i < 24; i++) begin
            v = int'($urandom % (1 << RES));
            run_frame(v);
            dead_clk();
        end
        cs_n = 1'b1;
        #1;
        check_cleared("R1 cleared mid frame");
        cyc(); cyc();

        // Slave mode: one frame per select pulse
        for (int i = 0; i < 4; i++) begin
            cs_n = 1'b0;
            run_frame(int'($urandom % (1 << RES)));
            cs_n = 1'b1;
            #1;
            check_cleared("R1 cleared after slave frame");
            cyc(); cyc();
        end

        // Shutdown aborts a running conversion
        cs_n = 1'b0;
        vin  = 12'd3001;
        for (int i = 0; i < 7; i++) cyc();
        shdn = 1'b1;
        #1;
        check("R9 shutdown status", int'(status), 0);
        check("R9 shutdown hold", int'(hold), 0);
        check("R9 shutdown output off", int'(sdo_oe), 0);
        check("R9 shutdown valid", int'(valid), 0);
        cyc(); cyc();
        check("R9 stays idle while shut down", int'(s_stat), 0);
        shdn = 1'b0;
        #1;
        check("R9 restart status", int'(status), 1);
        run_frame(int'($urandom % (1 << RES)));
        dead_clk();
        run_frame(1);
        cs_n = 1'b1;
        cyc(); cyc();

        // Select raised mid-frame, then a fresh frame
        cs_n = 1'b0;
        vin  = 12'd777;
        for (int i = 0; i < 9; i++) cyc();
        cs_n = 1'b1;
        #1;
        check("R10 abort status", int'(status), 0);
        check("R10 abort code", int'(code), 0);
        cyc(); cyc();
        cs_n = 1'b0;
        run_frame(3333);
        cs_n = 1'b1;
        cyc();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule